// File: doc/BRIEF.md
# Extended SMRAM control register with address decode

This block holds the 8-bit control register for the extended system-management memory region and the decode logic that acts on it. A simple register bus reaches the register at one byte offset. Bit 7 enables the high SMRAM alias and bit 0 enables a 1 MB top segment. Bit 6 is a sticky error flag: hardware sets it and software clears it by writing 1. Bits 5:3 are fixed at one and bits 2:1 are fixed at zero. A lock input freezes the two enable bits. A global SMRAM enable, supplied from outside, gates both regions.

On every CPU memory request the block reports whether high SMRAM and the top segment are active. It also returns the DRAM address. Inside the 128 KB high window, 0xFEDA0000–0xFEDBFFFF, with high SMRAM active, the address is moved down onto 0x000A0000–0x000BFFFF. Any other address passes through unchanged. A request that lands in an active protected range while the "in SMM" input is low sets the error flag.

Top module: `smram_ext_ctl`

## Requirements
- R1: After reset the register reads 0x38, and both the high-SMRAM and top-segment active outputs are 0.
- R2: A read at the register offset always returns 1 in bits 5:3 and 0 in bits 2:1, whatever was written.
- R3: With the lock input low, a write at offset 0x61 loads bit 7 (high enable) and bit 0 (segment enable). The new values read back from the next cycle on.
- R4: While the lock input is high, a write leaves bit 7 and bit 0 unchanged.
- R5: `hi_active` equals bit 7 AND `glob_en`. `tseg_active` equals bit 0 AND `glob_en`. Both are combinational.
- R6: When `hi_active` is 1 and the request address is within 0xFEDA0000–0xFEDBFFFF, `xlat_addr` is the address minus 0xFEDA0000 plus 0x000A0000. In every other case `xlat_addr` equals the request address. The output is combinational.
- R7: A valid request with `in_smm` low sets bit 6 on the next clock edge in either of two cases. The first is `hi_active` high with the address in the high window. The second is `tseg_active` high with the address in TSEG_BASE to TSEG_BASE+1 MB−1.
- R8: No error is set in these cases: `in_smm` is high, the region is inactive, the address is outside both windows, or `req_valid` is low.
- R9: A write at the offset with data bit 6 = 1 clears bit 6. With data bit 6 = 0, bit 6 keeps its value.
- R10: When an error event and a clearing write fall in the same cycle, bit 6 ends up set.
- R11: Writes at any other offset change nothing, and reads at any other offset return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register-bus write strobe |
| cfg_addr | input | 8 | Register-bus byte offset |
| cfg_wdata | input | 8 | Register-bus write data |
| cfg_rdata | output | 8 | Register-bus read data (combinational) |
| lock_in | input | 1 | Freezes the two enable bits while high |
| glob_en | input | 1 | Global SMRAM enable from outside |
| in_smm | input | 1 | CPU is in system-management mode |
| req_valid | input | 1 | CPU memory request present |
| req_addr | input | 32 | CPU request address |
| hi_active | output | 1 | High SMRAM alias active |
| tseg_active | output | 1 | Top segment active |
| xlat_addr | output | 32 | DRAM address after remap |

## Verification
The hardest case to reach is R10: a clearing write and an error-producing request in the same cycle. The bench drives both on one falling edge and then reads the flag back. Error detection also depends on five inputs together: global enable, the two bits, SMM state and the window. For that reason every combination of those inputs is swept. Each combination is tried against addresses one below, at, inside and one above both window edges. The model predicts the flag and the remap arithmetically.

// File: rtl/smram_ext_pkg.sv
package smram_ext_pkg;
    localparam int unsigned ADDR_W   = 32;
    localparam logic [ADDR_W-1:0] HI_BASE = 32'hFEDA_0000;
    localparam logic [ADDR_W-1:0] HI_SPAN = 32'h0002_0000;
    localparam logic [ADDR_W-1:0] LO_BASE = 32'h000A_0000;

    typedef struct packed {
        logic hi_en;
        logic err;
        logic tseg_en;
    } ctl_t;

    localparam ctl_t CTL_RST = '{hi_en: 1'b0, err: 1'b0, tseg_en: 1'b0};
endpackage

// File: rtl/smram_ext_reg.sv
module smram_ext_reg
    import smram_ext_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_hit,
    input  logic wr_hi,
    input  logic wr_clr,
    input  logic wr_tseg,
    input  logic lock_in,
    input  logic err_set,
    output ctl_t ctl_q
);
    ctl_t ctl_d;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_hit && !lock_in) begin
            ctl_d.hi_en   = wr_hi;
            ctl_d.tseg_en = wr_tseg;
        end
        if (wr_hit && wr_clr) begin
            ctl_d.err = 1'b0;
        end
        if (err_set) begin
            ctl_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end
endmodule

// File: rtl/smram_ext_decode.sv
module smram_ext_decode
    import smram_ext_pkg::*;
#(
    parameter logic [ADDR_W-1:0] TSEG_BASE  = 32'h07F0_0000,
    parameter logic [ADDR_W-1:0] TSEG_BYTES = 32'h0010_0000
) (
    input  logic              hi_bit,
    input  logic              tseg_bit,
    input  logic              glob_en,
    input  logic              in_smm,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              hi_active,
    output logic              tseg_active,
    output logic [ADDR_W-1:0] xlat_addr,
    output logic              err_set
);
    localparam logic [ADDR_W-1:0] HI_LAST   = HI_BASE + HI_SPAN - 1;
    localparam logic [ADDR_W-1:0] TSEG_LAST = TSEG_BASE + TSEG_BYTES - 1;
    localparam logic [ADDR_W-1:0] HI_SHIFT  = HI_BASE - LO_BASE;

    logic in_hi, in_tseg, hit_hi, hit_tseg;

    always_comb begin
        hi_active   = hi_bit & glob_en;
        tseg_active = tseg_bit & glob_en;
        in_hi       = (req_addr >= HI_BASE) && (req_addr <= HI_LAST);
        in_tseg     = (req_addr >= TSEG_BASE) && (req_addr <= TSEG_LAST);
        hit_hi      = hi_active && in_hi;
        hit_tseg    = tseg_active && in_tseg;
        xlat_addr   = hit_hi ? (req_addr - HI_SHIFT) : req_addr;
        err_set     = req_valid && !in_smm && (hit_hi || hit_tseg);
    end
endmodule

// File: rtl/smram_ext_ctl.sv
module smram_ext_ctl
    import smram_ext_pkg::*;
#(
    parameter logic [7:0]        REG_OFS    = 8'h61,
    parameter logic [ADDR_W-1:0] TSEG_BASE  = 32'h07F0_0000,
    parameter logic [ADDR_W-1:0] TSEG_BYTES = 32'h0010_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [7:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              lock_in,
    input  logic              glob_en,
    input  logic              in_smm,
    input  logic              req_valid,
    input  logic [31:0]       req_addr,
    output logic              hi_active,
    output logic              tseg_active,
    output logic [31:0]       xlat_addr
);
    localparam logic [2:0] FIXED_ONES = 3'b111;
    localparam logic [1:0] RSVD_ZERO  = 2'b00;

    ctl_t ctl_q;
    logic sel, wr_hit, err_set;
    logic hi_bit, tseg_bit, err_bit;
    logic unused_wbits;

    assign unused_wbits = ^cfg_wdata[5:1];
    assign sel      = (cfg_addr == REG_OFS);
    assign wr_hit   = cfg_wr && sel;
    assign hi_bit   = ctl_q.hi_en;
    assign tseg_bit = ctl_q.tseg_en;
    assign err_bit  = ctl_q.err;

    smram_ext_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hit  (wr_hit),
        .wr_hi   (cfg_wdata[7]),
        .wr_clr  (cfg_wdata[6]),
        .wr_tseg (cfg_wdata[0]),
        .lock_in (lock_in),
        .err_set (err_set),
        .ctl_q   (ctl_q)
    );

    smram_ext_decode #(
        .TSEG_BASE  (TSEG_BASE),
        .TSEG_BYTES (TSEG_BYTES)
    ) u_dec (
        .hi_bit      (hi_bit),
        .tseg_bit    (tseg_bit),
        .glob_en     (glob_en),
        .in_smm      (in_smm),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .hi_active   (hi_active),
        .tseg_active (tseg_active),
        .xlat_addr   (xlat_addr),
        .err_set     (err_set)
    );

    always_comb begin
        cfg_rdata = 8'h00;
        if (sel) cfg_rdata = {hi_bit, err_bit, FIXED_ONES, RSVD_ZERO, tseg_bit};
    end
endmodule

// File: rtl/smram_ext_chk.sv
module smram_ext_chk #(
    parameter logic [7:0]  REG_OFS    = 8'h61,
    parameter logic [31:0] TSEG_BASE  = 32'h07F0_0000,
    parameter logic [31:0] TSEG_BYTES = 32'h0010_0000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_wr,
    input logic [7:0]  cfg_addr,
    input logic [7:0]  cfg_wdata,
    input logic [7:0]  cfg_rdata,
    input logic        lock_in,
    input logic        glob_en,
    input logic        in_smm,
    input logic        req_valid,
    input logic [31:0] req_addr,
    input logic        hi_active,
    input logic        tseg_active,
    input logic [31:0] xlat_addr,
    input logic        hi_bit,
    input logic        tseg_bit,
    input logic        err_bit
);
    logic in_hi_win, in_ts_win;
    assign in_hi_win = (req_addr[31:17] == 15'h7F6D);
    assign in_ts_win = (req_addr >= TSEG_BASE) && (req_addr - TSEG_BASE < TSEG_BYTES);

    assert_fixed_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == REG_OFS) |-> (cfg_rdata[5:3] == 3'b111 && cfg_rdata[2:1] == 2'b00));

    assert_lock_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lock_in |=> (hi_bit == $past(hi_bit) && tseg_bit == $past(tseg_bit)));

    assert_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_en |-> (!hi_active && !tseg_active));

    assert_remap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_active && in_hi_win) |-> (xlat_addr[31:17] == 15'h0005 && xlat_addr[16:0] == req_addr[16:0]));

    assert_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_hi_win |-> (xlat_addr == req_addr));

    assert_err_hi_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !in_smm && hi_active && in_hi_win) |=> err_bit);

    assert_err_ts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !in_smm && tseg_active && in_ts_win) |=> err_bit);

    assert_no_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_bit && (!req_valid || in_smm)) |=> !err_bit);

    assert_w1c_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_addr == REG_OFS && cfg_wdata[6] && !req_valid) |=> !err_bit);

    assert_other_ofs_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr != REG_OFS) |-> (cfg_rdata == 8'h00));
endmodule

bind smram_ext_ctl smram_ext_chk #(
    .REG_OFS    (REG_OFS),
    .TSEG_BASE  (TSEG_BASE),
    .TSEG_BYTES (TSEG_BYTES)
) u_chk (.*);

// File: tb/sim_smram_ext_ctl.sv
module sim_smram_ext_ctl;
    localparam logic [7:0]  OFS     = 8'h61;
    localparam logic [31:0] HI_B    = 32'hFEDA_0000;
    localparam logic [31:0] HI_E    = 32'hFEDB_FFFF;
    localparam logic [31:0] TS_B    = 32'h07F0_0000;
    localparam logic [31:0] TS_E    = 32'h07FF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_addr = 8'h00;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic        lock_in = 1'b0;
    logic        glob_en = 1'b0;
    logic        in_smm = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = 32'h0;
    logic        hi_active, tseg_active;
    logic [31:0] xlat_addr;

    int checks = 0;
    int fails  = 0;
    logic m_hi = 1'b0, m_err = 1'b0, m_ts = 1'b0;
    logic [31:0] probes [10];

    always #4 clk = ~clk;

    smram_ext_ctl u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_reg(input string req);
        cfg_addr = OFS;
        #1;
        chk(req, {24'h0, cfg_rdata}, {24'h0, m_hi, m_err, 3'b111, 2'b00, m_ts});
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
        if (a == OFS) begin
            if (!lock_in) begin m_hi = d[7]; m_ts = d[0]; end
            if (d[6]) m_err = 1'b0;
        end
    endtask

    task automatic access(input logic [31:0] a, input logic smm);
        logic inhi, ints, set;
        logic [31:0] exp_x;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; in_smm = smm;
        #1;
        inhi  = (a >= HI_B) && (a <= HI_E);
        ints  = (a >= TS_B) && (a <= TS_E);
        exp_x = (m_hi && glob_en && inhi) ? (a - HI_B + 32'h000A_0000) : a;
        chk("R5 hi_active", {31'h0, hi_active}, {31'h0, m_hi & glob_en});
        chk("R5 tseg_active", {31'h0, tseg_active}, {31'h0, m_ts & glob_en});
        chk("R6 xlat_addr", xlat_addr, exp_x);
        set = !smm && glob_en && ((m_hi && inhi) || (m_ts && ints));
        @(negedge clk);
        req_valid = 1'b0; in_smm = 1'b0;
        if (set) m_err = 1'b1;
        check_reg(set ? "R7 error set" : "R8 no error");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        probes[0] = HI_B - 1; probes[1] = HI_B; probes[2] = HI_B + 32'h1234;
        probes[3] = HI_E;     probes[4] = HI_E + 1; probes[5] = TS_B - 1;
        probes[6] = TS_B;     probes[7] = TS_B + 32'h8_0001; probes[8] = TS_E;
        probes[9] = TS_E + 1;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_reg("R1 reset value");
        chk("R1 reset hi_active", {31'h0, hi_active}, 32'h0);
        chk("R1 reset tseg_active", {31'h0, tseg_active}, 32'h0);

        for (int v = 0; v < 256; v++) begin
            wr(OFS, v[7:0]);
            check_reg("R2 R3 unlocked write");
        end

        wr(OFS, 8'h81);
        lock_in = 1'b1;
        for (int v = 0; v < 256; v++) begin
            wr(OFS, v[7:0] & 8'hBF);
            check_reg("R4 locked write");
        end
        lock_in = 1'b0;

        wr(8'h60, 8'hFF);
        check_reg("R11 write other offset");
        wr(8'h62, 8'h00);
        check_reg("R11 write other offset");
        cfg_addr = 8'h60; #1;
        chk("R11 read other offset", {24'h0, cfg_rdata}, 32'h0);
        cfg_addr = 8'h62; #1;
        chk("R11 read other offset", {24'h0, cfg_rdata}, 32'h0);

        for (int c = 0; c < 16; c++) begin
            glob_en = c[0];
            wr(OFS, {c[1], 1'b1, 5'b00000, c[2]});
            check_reg("R9 clear by write one");
            for (int p = 0; p < 10; p++) access(probes[p], c[3]);
        end

        glob_en = 1'b1;
        wr(OFS, 8'h81);
        access(HI_B, 1'b0);
        wr(OFS, 8'h81 & 8'hBF);
        check_reg("R9 write zero keeps error");
        wr(OFS, 8'hC1);
        check_reg("R9 write one clears error");

        @(negedge clk);
        req_valid = 1'b1; req_addr = TS_B; in_smm = 1'b0;
        cfg_wr = 1'b1; cfg_addr = OFS; cfg_wdata = 8'hC1;
        @(negedge clk);
        cfg_wr = 1'b0; req_valid = 1'b0;
        m_err = 1'b1;
        check_reg("R10 set beats clear");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule